// File: doc/BRIEF.md
# Keyed Serial Clock Access Port

This block sits beside a byte-wide memory and watches its bus: chip enable, output enable, write enable and data bit 0. Each bus cycle arrives as a one-clock strobe. While idle, the block looks for a 64-bit unlock key. The key arrives one bit per write cycle on data bit 0. These key writes still go to memory as usual, so software normally sets aside one scratch address for them.

After a full key match, the next 64 counted bus cycles go to the timekeeping registers instead of memory. On these cycles the block inhibits memory access. It either shifts out a snapshot of the 64 clock register bits or shifts in a new 64-bit image. A new image is committed with a single load strobe at the end.

A read cycle during recognition restarts it. A wrong key bit locks recognition out until the next read. An external reset input can abandon a transfer unless the clock's own ignore bit masks it.

Top module: `keyed_clock_port`

## Requirements
- R1: While rst_n is low and at the first clock after release, mem_inhibit, dq0_out, clk_capture and clk_load are all 0.
- R2: The unlock key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C. Byte 0 is sent first, each byte least significant bit first, so key bit i is bit i of 64'h5CA33AC55CA33AC5. The transfer window opens after 64 write cycles whose dq0_in equals key bits 0 to 63 in turn. A write cycle is cyc_stb=1, ce_n=0, we_n=0.
- R3: A write cycle whose dq0_in differs from the key bit at the pointer freezes the pointer. All later write cycles are then ignored for recognition until a read cycle occurs.
- R4: A read cycle (cyc_stb=1, ce_n=0, we_n=1, oe_n=0) during recognition clears the pointer and the freeze. A full key must then follow.
- R5: mem_inhibit stays 0 during all key write cycles, including the last one. It is 1 for exactly the 64 counted transfer cycles that follow, and returns to 0 after the 64th.
- R6: A read transfer is one whose first transfer cycle is a read. On that first cycle, clk_capture pulses and clk_regs_in is taken as a snapshot. On the k-th transfer cycle (k = 0 to 63), dq0_out shows snapshot bit k, so register 0 bit 0 comes first and register 7 bit 7 last. dq0_out is 0 outside a transfer.
- R7: A write transfer is one whose first transfer cycle is a write. The dq0_in of its k-th cycle becomes clk_regs_out bit k. clk_load pulses for exactly one clock, on the clock after the 64th cycle, and never earlier.
- R8: When a transfer window ends, recognition restarts with the pointer at bit 0 and no freeze. A full key then unlocks again without a read in between.
- R9: The block ignores these cycles for both recognition and transfer counting: any strobe with ce_n=1, any cycle with ce_n=0, we_n=1 and oe_n=1, and any clock without cyc_stb.
- R10: If abort_n is low during a transfer while abort_mask is 0, the transfer is abandoned. mem_inhibit falls on the next clock, no clk_load pulse occurs, and recognition restarts. With abort_mask at 1, abort_n has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb | input | 1 | One-clock strobe marking a bus cycle |
| ce_n | input | 1 | Chip enable of the cycle, active low |
| oe_n | input | 1 | Output enable of the cycle, active low |
| we_n | input | 1 | Write enable of the cycle, active low |
| dq0_in | input | 1 | Data bit 0 written by the bus |
| abort_n | input | 1 | Active-low transfer abort request |
| abort_mask | input | 1 | Reset-ignore bit from the clock registers; 1 masks abort_n |
| clk_regs_in | input | 64 | Current image of the eight clock registers |
| dq0_out | output | 1 | Data bit 0 returned on transfer reads |
| mem_inhibit | output | 1 | Blocks the memory array during transfer cycles |
| clk_capture | output | 1 | Snapshot strobe on the first read of a transfer |
| clk_regs_out | output | 64 | New clock register image |
| clk_load | output | 1 | One-clock strobe committing clk_regs_out |

## Verification
The hardest state to reach is a frozen pointer that is later followed by the correct continuation of the key. This must be shown not to unlock, even though the same bits unlock a fresh attempt. The stimulus sends a correct prefix, one wrong bit and then the rest of the key. It then checks that the following cycles are not inhibited, and that a read followed by the full key does unlock. The same approach covers a read that cuts a key in half, and a key that runs on into ignored chip-disabled or enable-less cycles.

// File: rtl/keyed_clock_port.sv
module keyed_clock_port #(
  parameter int          N   = 64,
  parameter logic [63:0] KEY = 64'h5CA33AC5_5CA33AC5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cyc_stb,
  input  logic         ce_n,
  input  logic         oe_n,
  input  logic         we_n,
  input  logic         dq0_in,
  input  logic         abort_n,
  input  logic         abort_mask,
  input  logic [N-1:0] clk_regs_in,
  output logic         dq0_out,
  output logic         mem_inhibit,
  output logic         clk_capture,
  output logic [N-1:0] clk_regs_out,
  output logic         clk_load
);
  localparam int            CW   = $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic          in_xfer, frozen, dir_wr;
  logic [CW-1:0] ptr, cnt;
  logic [N-1:0]  sh;

  wire rd_cyc = cyc_stb & ~ce_n & we_n & ~oe_n;
  wire wr_cyc = cyc_stb & ~ce_n & ~we_n;
  wire first  = (cnt == '0);
  wire is_wr  = first ? wr_cyc : dir_wr;
  wire abort  = in_xfer & ~abort_n & ~abort_mask;

  assign mem_inhibit  = in_xfer;
  assign clk_capture  = in_xfer & first & rd_cyc;
  assign dq0_out      = in_xfer & (first ? clk_regs_in[0] : (~dir_wr & sh[0]));
  assign clk_regs_out = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_xfer  <= 1'b0;
      frozen   <= 1'b0;
      dir_wr   <= 1'b0;
      ptr      <= '0;
      cnt      <= '0;
      sh       <= '0;
      clk_load <= 1'b0;
    end else begin
      clk_load <= 1'b0;
      if (abort) begin
        in_xfer <= 1'b0;
        ptr     <= '0;
        frozen  <= 1'b0;
        cnt     <= '0;
      end else if (!in_xfer) begin
        if (rd_cyc) begin
          ptr    <= '0;
          frozen <= 1'b0;
        end else if (wr_cyc && !frozen) begin
          if (dq0_in == KEY[ptr]) begin
            if (ptr == LAST) begin
              in_xfer <= 1'b1;
              ptr     <= '0;
              cnt     <= '0;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end else begin
            frozen <= 1'b1;
          end
        end
      end else if (rd_cyc || wr_cyc) begin
        if (first) dir_wr <= wr_cyc;
        if (is_wr) sh <= {dq0_in, sh[N-1:1]};
        else       sh <= (first ? clk_regs_in : sh) >> 1;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          in_xfer  <= 1'b0;
          cnt      <= '0;
          ptr      <= '0;
          frozen   <= 1'b0;
          clk_load <= is_wr;
        end
      end
    end
  end
endmodule

// File: rtl/keyed_clock_port_chk.sv
module keyed_clock_port_chk #(
  parameter int N = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cyc_stb,
  input logic         ce_n,
  input logic         oe_n,
  input logic         we_n,
  input logic         dq0_in,
  input logic         abort_n,
  input logic         abort_mask,
  input logic [N-1:0] clk_regs_in,
  input logic         dq0_out,
  input logic         mem_inhibit,
  input logic         clk_capture,
  input logic [N-1:0] clk_regs_out,
  input logic         clk_load
);
  wire rd = cyc_stb & ~ce_n & we_n & ~oe_n;
  wire wr = cyc_stb & ~ce_n & ~we_n;

  p_load_after_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_load |-> $past(mem_inhibit));
  p_load_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_load |=> !clk_load);
  p_capture_in_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_capture |-> (mem_inhibit && rd));
  p_dq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_inhibit |-> !dq0_out);
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_inhibit && !abort_n && !abort_mask) |=> (!mem_inhibit && !clk_load));
  p_read_no_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_inhibit && rd) |=> !mem_inhibit);
  p_unlock_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_inhibit) |-> $past(wr));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_inhibit && !(rd || wr) && abort_n) |=> mem_inhibit);
endmodule

bind keyed_clock_port keyed_clock_port_chk #(.N(N)) u_chk (.*);

// File: tb/sim_keyed_clock_port.sv
`timescale 1ns/1ps
module sim_keyed_clock_port;
  localparam logic [63:0] KEY = 64'h5CA33AC5_5CA33AC5;

  logic clk = 0, rst_n = 0;
  logic cyc_stb = 0, ce_n = 1, oe_n = 1, we_n = 1, dq0_in = 0;
  logic abort_n = 1, abort_mask = 0;
  logic [63:0] clk_regs_in = '0;
  logic dq0_out, mem_inhibit, clk_capture, clk_load;
  logic [63:0] clk_regs_out;
  logic q, inh, cap;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  keyed_clock_port u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic c, logic w, logic o, logic d);
    @(negedge clk);
    cyc_stb = 1; ce_n = c; we_n = w; oe_n = o; dq0_in = d;
    #2; q = dq0_out; inh = mem_inhibit; cap = clk_capture;
    @(negedge clk);
    cyc_stb = 0; ce_n = 1; we_n = 1; oe_n = 1;
    #1;
  endtask

  task automatic rd();              cyc(0, 1, 0, 0); endtask
  task automatic wr(logic d);       cyc(0, 0, 1, d); endtask

  task automatic send_key(int from, int to, output int bad_inh);
    bad_inh = 0;
    for (int i = from; i <= to; i++) begin
      wr(KEY[i]);
      if (inh) bad_inh++;
    end
  endtask

  task automatic t_reset();
    chk("R1 inhibit", mem_inhibit, 0);
    chk("R1 dq0", dq0_out, 0);
    chk("R1 capture", clk_capture, 0);
    chk("R1 load", clk_load, 0);
  endtask

  task automatic t_read_xfer();
    int b, bad = 0, badi = 0;
    logic [63:0] snap = 64'hA5F0_3C96_0FF1_7E24;
    clk_regs_in = snap;
    rd();
    send_key(0, 63, b);
    chk("R5 key writes not inhibited", b, 0);
    chk("R2 unlocked", mem_inhibit, 1);
    for (int k = 0; k < 64; k++) begin
      rd();
      if (k == 0) begin
        chk("R6 capture first", cap, 1);
        clk_regs_in = ~snap;
      end else if (cap) bad++;
      if (q !== snap[k]) bad++;
      if (!inh) badi++;
    end
    chk("R6 read bits and capture", bad, 0);
    chk("R5 inhibit over window", badi, 0);
    chk("R5 window closed", mem_inhibit, 0);
    chk("R6 dq0 quiet", dq0_out, 0);
  endtask

  task automatic t_write_xfer(logic [63:0] v);
    int b, early = 0;
    rd();
    send_key(0, 63, b);
    for (int k = 0; k < 64; k++) begin
      wr(v[k]);
      if (k < 63 && clk_load) early++;
    end
    chk("R7 no early load", early, 0);
    chk("R7 load pulse", clk_load, 1);
    chk("R7 image", clk_regs_out, v);
    @(negedge clk);
    chk("R7 load single", clk_load, 0);
  endtask

  task automatic t_mismatch();
    int b;
    rd();
    send_key(0, 9, b);
    wr(~KEY[10]);
    send_key(10, 63, b);
    send_key(0, 20, b);
    chk("R3 frozen no unlock", b + mem_inhibit, 0);
    rd();
    send_key(0, 63, b);
    chk("R3 read clears freeze", mem_inhibit, 1);
    for (int k = 0; k < 64; k++) rd();
  endtask

  task automatic t_read_abort();
    int b;
    rd();
    send_key(0, 29, b);
    rd();
    send_key(30, 63, b);
    chk("R4 read restarts pointer", mem_inhibit, 0);
    rd();
    send_key(0, 29, b);
    rd();
    send_key(0, 63, b);
    chk("R4 fresh key after read", mem_inhibit, 1);
    for (int k = 0; k < 64; k++) rd();
  endtask

  task automatic t_restart();
    int b;
    t_write_xfer(64'h0123_4567_89AB_CDEF);
    send_key(0, 63, b);
    chk("R8 pointer cleared after window", mem_inhibit, 1);
    for (int k = 0; k < 64; k++) rd();
    chk("R8 closed", mem_inhibit, 0);
  endtask

  task automatic t_ignored();
    int b;
    logic [63:0] v = 64'hDEAD_BEEF_CAFE_F00D;
    rd();
    send_key(0, 31, b);
    cyc(1, 0, 1, ~KEY[32]);
    cyc(0, 1, 1, 0);
    cyc(1, 1, 0, 0);
    send_key(32, 63, b);
    chk("R9 ignored cycles in key", mem_inhibit, 1);
    for (int k = 0; k < 64; k++) begin
      wr(v[k]);
      if (k == 10) begin
        cyc(1, 0, 1, 1);
        cyc(0, 1, 1, 1);
        repeat (3) @(negedge clk);
        chk("R9 window held", mem_inhibit, 1);
      end
    end
    chk("R9 image intact", clk_regs_out, v);
  endtask

  task automatic t_abort();
    int b, loads = 0;
    logic [63:0] v = 64'h1357_9BDF_2468_ACE0;
    logic [63:0] prev;
    rd();
    send_key(0, 63, b);
    for (int k = 0; k < 20; k++) wr(~v[k]);
    prev = clk_regs_out;
    abort_mask = 0; abort_n = 0;
    @(negedge clk); #1;
    if (clk_load) loads++;
    abort_n = 1;
    chk("R10 abort closes", mem_inhibit, 0);
    for (int k = 0; k < 44; k++) begin
      wr(v[k]);
      if (clk_load) loads++;
    end
    chk("R10 no load after abort", loads, 0);
    chk("R10 no unlock", mem_inhibit, 0);
    rd();
    send_key(0, 63, b);
    for (int k = 0; k < 20; k++) wr(v[k]);
    abort_mask = 1; abort_n = 0;
    @(negedge clk); #1;
    chk("R10 masked abort ignored", mem_inhibit, 1);
    abort_n = 1;
    for (int k = 20; k < 64; k++) wr(v[k]);
    chk("R10 masked load", clk_load, 1);
    chk("R10 masked image", clk_regs_out, v);
    abort_mask = 0;
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_read_xfer();
    t_write_xfer(64'hF0E1_D2C3_B4A5_9687);
    t_write_xfer(64'h8000_0000_0000_0001);
    t_mismatch();
    t_read_abort();
    t_restart();
    t_ignored();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #1_200_000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule